// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 values and sets one condition flag from the result. One bit of the operation code picks binary32 or binary64. In binary32 mode only the low 32 bits of each 64-bit operand bus are used. The operation code can select one of three kinds of test:

- an ordered predicate;
- a variant of that predicate that also reports true when either operand is NaN;
- a pure test for an unordered pair.

No destination register is written. The only outputs are the flag, a one-cycle write enable for it, and an invalid-operation indication.

The unit sits beside the integer status register of a processor pipeline. The issue stage raises a start strobe together with a compare opcode and two operand values. In the next cycle the unit presents the new flag and pulses the write enable. An opcode outside the compare space is dropped and the held flag keeps its value.

Magnitude ordering works on a monotonic key. For a negative value every bit of the encoding is inverted. For a positive value only the sign bit is inverted. A single unsigned comparator then orders all finite values, subnormals and infinities. The two signed zeros are handled as a special case so that they compare equal.

Top module: `fcmp_flag_unit`

## Requirements
- R1: The opcode is 8 bits. Bits [7:6] must be 00 and bit 3 must be 1. Bit 4 selects binary64 (1) or binary32 (0). Bit 5 selects the unordered variant. Bits [2:0] pick the predicate: 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le. Predicate code 6 is the pure unordered test and is valid only when bit 5 is set. The recognised opcodes are therefore 0x08-0x0d, 0x18-0x1d, 0x28-0x2e and 0x38-0x3e.
- R2: In binary32 mode the result depends only on bits [31:0] of each operand. Bits [63:32] are ignored.
- R3: An ordered eq, gt, ge, lt or le evaluates false when either operand is NaN. An ordered ne evaluates true in that case.
- R4: For an unordered variant (bit 5 set, predicate 0-5), the flag is the OR of "either operand is NaN" and the matching ordered predicate.
- R5: Predicate code 6 (0x2e, 0x3e) sets the flag exactly when at least one operand is NaN.
- R6: +0 and -0 compare equal under every predicate.
- R7: For non-NaN operands, the predicates follow numeric order, including subnormals and both infinities.
- R8: For every recognised opcode, `invalid_o` is 1 in the result cycle if and only if either operand is a signalling NaN. A signalling NaN has the exponent all ones, a nonzero fraction and the fraction MSB at 0.
- R9: A start strobe with a recognised opcode updates `flag_o` and raises `flag_we_o` on the next clock edge. `flag_we_o` stays high for that one cycle only.
- R10: A start strobe with an unrecognised opcode raises neither `flag_we_o` nor `invalid_o`, and `flag_o` keeps its previous value.
- R11: A synchronous active-high reset clears `flag_o`, `flag_we_o` and `invalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Compare request strobe |
| op_i | input | 8 | Compare operation code |
| a_i | input | 64 | First operand (binary32 in bits [31:0]) |
| b_i | input | 64 | Second operand (binary32 in bits [31:0]) |
| flag_o | output | 1 | Held condition flag |
| flag_we_o | output | 1 | One-cycle flag write enable |
| invalid_o | output | 1 | Signalling-NaN operand seen, valid with flag_we_o |

## Verification
Each error class shows at the ports in the cycle right after the strobe, because the only state is the registered flag.

- A wrong order key or a missed signed-zero case gives a wrong flag for particular value pairs. The bench sweeps every pair of special and ordinary values, under every compare opcode, in both precisions.
- A decode error appears in two ways. A recognised opcode can fail to pulse the write enable. An illegal opcode can overwrite the held flag. The full 256-code sweep exposes both in the first cycle after the bad strobe.
- A write enable stuck high is caught one cycle later, by the idle-cycle check.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    parameter int unsigned OP_W   = 8;
    parameter int unsigned DBL_W  = 64;
    parameter int unsigned SGL_W  = 32;
    parameter int unsigned DBL_EW = 11;
    parameter int unsigned SGL_EW = 8;

    typedef enum logic [2:0] {
        PR_EQ = 3'd0,
        PR_NE = 3'd1,
        PR_GT = 3'd2,
        PR_GE = 3'd3,
        PR_LT = 3'd4,
        PR_LE = 3'd5,
        PR_UN = 3'd6,
        PR_XX = 3'd7
    } pred_e;

    typedef struct packed {
        logic  valid;
        logic  dbl;
        logic  unord;
        pred_e pred;
    } cmd_t;

    typedef struct packed {
        logic             nan;
        logic             snan;
        logic             zero;
        logic [DBL_W-1:0] key;
    } opnd_t;

    // Decode the compare opcode space (R1)
    function automatic cmd_t decode_op(input logic [OP_W-1:0] op);
        cmd_t c;
        logic ok_pred;
        c.dbl   = op[4];
        c.unord = op[5];
        c.pred  = pred_e'(op[2:0]);
        ok_pred = (op[2:0] <= 3'd5) || (op[2:0] == 3'd6 && op[5]);
        c.valid = (op[OP_W-1:6] == '0) && op[3] && ok_pred;
        return c;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int unsigned DW = DBL_W,
    parameter int unsigned SW = SGL_W,
    parameter int unsigned DE = DBL_EW,
    parameter int unsigned SE = SGL_EW
) (
    input  logic [DW-1:0] raw_i,
    input  logic          dbl_i,
    output opnd_t         info_o
);
    localparam int unsigned DF = DW - 1 - DE;
    localparam int unsigned SF = SW - 1 - SE;
    localparam logic [DW-1:0] D_SGN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [SW-1:0] S_SGN = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0] lo;
    logic [DE-1:0] d_exp;
    logic [DF-1:0] d_frc;
    logic [SE-1:0] s_exp;
    logic [SF-1:0] s_frc;
    logic          d_nan, s_nan;
    logic          d_snan, s_snan;
    logic          d_zero, s_zero;
    logic [DW-1:0] d_key, s_key;
    logic [SW-1:0] s_key_n;

    always_comb begin
        lo    = raw_i[SW-1:0];
        d_exp = raw_i[DW-2 -: DE];
        d_frc = raw_i[DF-1:0];
        s_exp = lo[SW-2 -: SE];
        s_frc = lo[SF-1:0];

        d_nan  = (&d_exp) && (|d_frc);
        s_nan  = (&s_exp) && (|s_frc);
        d_snan = d_nan && !d_frc[DF-1];
        s_snan = s_nan && !s_frc[SF-1];
        d_zero = ~|raw_i[DW-2:0];
        s_zero = ~|lo[SW-2:0];

        // Monotonic key: negatives fully inverted, positives sign-flipped
        d_key   = raw_i[DW-1] ? ~raw_i : (raw_i ^ D_SGN);
        s_key_n = lo[SW-1] ? ~lo : (lo ^ S_SGN);
        s_key   = {{(DW-SW){1'b0}}, s_key_n};

        info_o.nan  = dbl_i ? d_nan  : s_nan;
        info_o.snan = dbl_i ? d_snan : s_snan;
        info_o.zero = dbl_i ? d_zero : s_zero;
        info_o.key  = dbl_i ? d_key  : s_key;
    end

endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
    import fcmp_pkg::*;
(
    input  cmd_t  cmd_i,
    input  opnd_t a_i,
    input  opnd_t b_i,
    output logic  res_o
);
    logic unord, both_zero, k_eq, k_lt, k_gt, eq, lt, gt, ordered;

    always_comb begin
        unord     = a_i.nan | b_i.nan;
        both_zero = a_i.zero & b_i.zero;
        k_eq      = (a_i.key == b_i.key);
        k_lt      = (a_i.key <  b_i.key);
        k_gt      = (a_i.key >  b_i.key);
        eq        = k_eq | both_zero;
        lt        = k_lt & !both_zero;
        gt        = k_gt & !both_zero;

        unique case (cmd_i.pred)
            PR_EQ:   ordered = !unord & eq;
            PR_NE:   ordered = unord | !eq;
            PR_GT:   ordered = !unord & gt;
            PR_GE:   ordered = !unord & (gt | eq);
            PR_LT:   ordered = !unord & lt;
            PR_LE:   ordered = !unord & (lt | eq);
            default: ordered = 1'b0;
        endcase

        if (cmd_i.pred == PR_UN)
            res_o = unord;
        else if (cmd_i.unord)
            res_o = unord | ordered;
        else
            res_o = ordered;
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [DBL_W-1:0] a_i,
    input  logic [DBL_W-1:0] b_i,
    output logic             flag_o,
    output logic             flag_we_o,
    output logic             invalid_o
);
    localparam int unsigned N_OPND = 2;

    cmd_t             cmd;
    opnd_t            info [N_OPND];
    logic [DBL_W-1:0] raw  [N_OPND];
    logic             res;
    logic             fire;

    assign cmd    = decode_op(op_i);
    assign raw[0] = a_i;
    assign raw[1] = b_i;
    assign fire   = start_i & cmd.valid;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fcmp_classify #(
            .DW(DBL_W), .SW(SGL_W), .DE(DBL_EW), .SE(SGL_EW)
        ) cls_i (
            .raw_i (raw[g]),
            .dbl_i (cmd.dbl),
            .info_o(info[g])
        );
    end

    fcmp_eval eval_i (
        .cmd_i(cmd),
        .a_i  (info[0]),
        .b_i  (info[1]),
        .res_o(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o    <= 1'b0;
            flag_we_o <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            flag_we_o <= fire;
            invalid_o <= fire & (info[0].snan | info[1].snan);
            if (fire)
                flag_o <= res;
        end
    end

    // R9: no write enable without a strobe in the previous cycle
    a_r9_no_we_without_start: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !flag_we_o);

    // R10: the flag holds whenever it is not written
    a_r10_flag_held: assert property (@(posedge clk) disable iff (rst)
        !flag_we_o |-> $stable(flag_o));

    // R10: an illegal opcode never produces a write
    a_r10_bad_op_silent: assert property (@(posedge clk) disable iff (rst)
        (start_i && !cmd.valid) |=> (!flag_we_o && !invalid_o));

    // R8: the invalid indication only accompanies a write
    a_r8_invalid_with_we: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> flag_we_o);

    // R5: the pure unordered test follows the NaN detectors
    a_r5_unordered_only: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd.pred == PR_UN) |-> (res == (info[0].nan | info[1].nan)));

    // R6: signed zeros compare equal
    a_r6_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd.pred == PR_EQ && info[0].zero && info[1].zero) |-> res);

    // R3: ordered predicates other than ne are false on NaN
    a_r3_nan_ordered_false: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd.unord && cmd.pred != PR_NE && (info[0].nan || info[1].nan)) |-> !res);

endmodule

// File: tb/fcmp_flag_unit_tb.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb_top;

    localparam int N_VAL = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        flag_o, flag_we_o, invalid_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fcmp_flag_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i),
        .flag_o(flag_o), .flag_we_o(flag_we_o), .invalid_o(invalid_o)
    );

    function automatic logic [31:0] sp_bits(input int i);
        case (i)
            0:  return 32'h0000_0000;
            1:  return 32'h8000_0000;
            2:  return 32'h3F80_0000;
            3:  return 32'hBF80_0000;
            4:  return 32'h4000_0000;
            5:  return 32'h7F80_0000;
            6:  return 32'hFF80_0000;
            7:  return 32'h0000_0001;
            8:  return 32'h8000_0001;
            9:  return 32'h7FC0_0000;
            10: return 32'h7F80_0001;
            default: return 32'h3F80_0001;
        endcase
    endfunction

    function automatic real sp_val(input int i);
        real inf;
        inf = $bitstoreal(64'h7FF0_0000_0000_0000);
        case (i)
            0:  return 0.0;
            1:  return -0.0;
            2:  return 1.0;
            3:  return -1.0;
            4:  return 2.0;
            5:  return inf;
            6:  return -inf;
            7:  return 1.401298464324817e-45;
            8:  return -1.401298464324817e-45;
            9:  return 0.0;
            10: return 0.0;
            default: return 1.00000011920928955078125;
        endcase
    endfunction

    function automatic logic [63:0] dp_bits(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h8000_0000_0000_0000;
            2:  return 64'h3FF0_0000_0000_0000;
            3:  return 64'hBFF0_0000_0000_0000;
            4:  return 64'h4000_0000_0000_0000;
            5:  return 64'h7FF0_0000_0000_0000;
            6:  return 64'hFFF0_0000_0000_0000;
            7:  return 64'h0000_0000_0000_0001;
            8:  return 64'h8000_0000_0000_0001;
            9:  return 64'h7FF8_0000_0000_0000;
            10: return 64'h7FF0_0000_0000_0001;
            default: return 64'h3FF0_0000_0000_0001;
        endcase
    endfunction

    // NaN classes computed from the field layout of each format
    function automatic bit is_nan(input logic [63:0] v, input bit dbl);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [63:0] v, input bit dbl);
        if (dbl) return is_nan(v, 1'b1) && !v[51];
        return is_nan(v, 1'b0) && !v[22];
    endfunction

    function automatic bit model(input int p, input bit u, input bit un,
                                 input real va, input real vb);
        bit ord;
        if (p == 6) return un;
        case (p)
            0: ord = !un && (va == vb);
            1: ord = un || (va != vb);
            2: ord = !un && (va > vb);
            3: ord = !un && (va >= vb);
            4: ord = !un && (va < vb);
            default: ord = !un && (va <= vb);
        endcase
        return u ? (un || ord) : ord;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [63:0] a,
                          input logic [63:0] b, input bit exp_ok,
                          input bit exp_flag, input bit exp_inv,
                          input string tag);
        logic prior;
        @(negedge clk);
        prior   = flag_o;
        start_i = 1'b1;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        @(negedge clk);
        start_i = 1'b0;
        if (exp_ok) begin
            chk(flag_we_o == 1'b1, "R9 we pulse", flag_we_o, 1);
            chk(flag_o == exp_flag, tag, flag_o, exp_flag);
            chk(invalid_o == exp_inv, "R8 invalid", invalid_o, exp_inv);
        end else begin
            chk(flag_we_o == 1'b0, "R10 no we", flag_we_o, 0);
            chk(flag_o == prior, "R10 flag held", flag_o, prior);
            chk(invalid_o == 1'b0, "R10 no invalid", invalid_o, 0);
        end
        prior = flag_o;
        @(negedge clk);
        chk(flag_we_o == 1'b0, "R9 single cycle", flag_we_o, 0);
        chk(flag_o == prior, "R9 flag stable", flag_o, prior);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(flag_o == 1'b0, "R11 flag reset", flag_o, 0);
        chk(flag_we_o == 1'b0, "R11 we reset", flag_we_o, 0);
        chk(invalid_o == 1'b0, "R11 invalid reset", invalid_o, 0);
        rst = 1'b0;

        // Value-pair sweep over every compare opcode, both precisions
        for (int prec = 0; prec < 2; prec++) begin
            for (int u = 0; u < 2; u++) begin
                for (int p = 0; p < 7; p++) begin
                    if (p == 6 && u == 0) continue;
                    for (int i = 0; i < N_VAL; i++) begin
                        for (int j = 0; j < N_VAL; j++) begin
                            logic [7:0]  op;
                            logic [63:0] a, b;
                            real         va, vb;
                            bit          un, inv, ef;
                            string       tag;
                            op = {2'b00, u[0], prec[0], 1'b1, p[2:0]};
                            if (prec == 1) begin
                                a  = dp_bits(i);
                                b  = dp_bits(j);
                                va = $bitstoreal(a);
                                vb = $bitstoreal(b);
                            end else begin
                                // R2: junk in the upper half must not matter
                                a  = {32'h7FF8_0000 ^ 32'(i * 977), sp_bits(i)};
                                b  = {32'hFFF0_0001 ^ 32'(j * 313), sp_bits(j)};
                                va = sp_val(i);
                                vb = sp_val(j);
                            end
                            un  = is_nan(a, prec[0]) || is_nan(b, prec[0]);
                            inv = is_snan(a, prec[0]) || is_snan(b, prec[0]);
                            ef  = model(p, u[0], un, va, vb);
                            if (p == 6)        tag = "R5 unordered test";
                            else if (un)       tag = u ? "R4 unordered variant" : "R3 ordered NaN";
                            else if (i < 2 && j < 2) tag = "R6 signed zero";
                            else               tag = "R7 ordering";
                            if (prec == 0) tag = {"R2 ", tag};
                            run_op(op, a, b, 1'b1, ef, inv, tag);
                        end
                    end
                end
            end
        end

        // R1 / R10: full opcode sweep with a signalling NaN operand
        for (int k = 0; k < 256; k++) begin
            logic [7:0]  op;
            bit          ok, dbl;
            logic [63:0] sa, sb;
            op  = 8'(k);
            dbl = op[4];
            ok  = (op[7:6] == 2'b00) && op[3] &&
                  ((op[2:0] <= 3'd5) || (op[2:0] == 3'd6 && op[5]));
            // preload a known flag value, alternating with the opcode
            run_op(8'h18, 64'h3FF0_0000_0000_0000,
                   k[0] ? 64'h3FF0_0000_0000_0000 : 64'h4000_0000_0000_0000,
                   1'b1, k[0], 1'b0, "R1 preload");
            sa = 64'h7FF0_0000_7F80_0001;
            sb = 64'h3FF0_0000_3F80_0000;
            run_op(op, sa, sb, ok,
                   model(int'(op[2:0]), op[5], 1'b1, 0.0, 1.0),
                   is_snan(sa, dbl), ok ? "R1 decode" : "R10 illegal");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule